// File: doc/BRIEF.md
# MDIO Management Master

This block is a hardware master for the two-wire management bus that configures Ethernet PHYs. A single-cycle request carries a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block serialises a full management frame: a run of high preamble bits, the start and opcode fields, both addresses, the turnaround slot and 16 data bits. It then reports completion with a one-cycle pulse. Reads return 16 bits of data and an error flag.

The management clock is made from the system clock. The half-period is a fixed number of system cycles set by a parameter, chosen so the management clock stays at or below 2.5 MHz. The data line is driven through an output-enable, so the bidirectional pad can be released while the PHY answers. Every transaction uses the same number of management clock cycles. With the default 32-bit preamble that number is 64, so read and write timing are identical.

Top module: `mdio_master`

## Requirements
- R1: Each transaction starts with PRE_LEN (default 32) management clock cycles during which mdio_oe=1 and mdio_o=1.
- R2: After the preamble the line carries, most-significant bit first, start field 01, then opcode 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register address. mdio_o changes only while mdc is low.
- R3: Each mdc half-period lasts exactly DIV system clocks. While idle, mdc is low and mdio_oe=1.
- R4: On a read, mdio_oe goes low at the start of management cycle PRE_LEN+14 while mdc is low, with no added mdc edge. It stays low for the remaining 18 cycles.
- R5: On a read, mdio_i is sampled just before the rising mdc edge of cycle PRE_LEN+15. If it is high, rd_err=1 and rd_data=0, and all 64 mdc cycles still run.
- R6: On a read with no error, 16 bits are sampled before the rising edges of cycles PRE_LEN+16 to PRE_LEN+31 and returned MSB first on rd_data.
- R7: After a read, mdio_oe returns high while mdc is low, with no extra mdc edge.
- R8: On a write, the line carries the turnaround pattern 10 and then the 16 data bits MSB first. mdio_oe stays high throughout and afterwards.
- R9: busy is high from acceptance until done. done is a one-cycle pulse. A request presented while busy is ignored.
- R10: A write completion reports rd_err=0 and rd_data=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, zero on error or write |
| rd_err | output | 1 | PHY did not answer the turnaround |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench models a PHY that answers on each rising mdc edge, and it can also model a missing PHY that leaves the line pulled high. A missing PHY shows whether the design returns the sampled ones instead of zero, or cuts the mdc burst short after an error. Reads whose data are all ones and all zeros expose a one-slot error in the sample point or the shift order, which would show as a rotated or truncated rd_data. Frames to the extreme addresses and a request injected mid-transaction check field order and the busy lock-out. A design that mixed up either would corrupt the captured frame or change the mdc edge count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   localparam logic [1:0] START_BITS = 2'b01;
   localparam logic [1:0] OPC_READ   = 2'b10;
   localparam logic [1:0] OPC_WRITE  = 2'b01;
   localparam logic [1:0] TURN_WRITE = 2'b10;
   localparam int ADDR_W    = 5;
   localparam int DATA_W    = 16;
   localparam int HDR_BITS  = 4 + 2 * ADDR_W;
   localparam int BODY_BITS = HDR_BITS + 2 + DATA_W;

   function automatic logic [BODY_BITS-1:0] build_body(
      input logic              wr,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] rga,
      input logic [DATA_W-1:0] wd);
      logic [1:0] opc;
      opc = wr ? OPC_WRITE : OPC_READ;
      return {START_BITS, opc, phy, rga, TURN_WRITE, wd};
   endfunction
endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("mdio_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[0] <= 1'b1;
               else        chain[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[i] <= 1'b1;
               else        chain[i] <= chain[i-1];
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/mdio_divider.sv
module mdio_divider #(
   parameter int DIV = 25
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
   logic [CW-1:0] cnt;

   generate
      if (DIV < 2) begin : g_bad
         $error("mdio_divider needs DIV of at least 2");
      end
   endgenerate

   assign tick = run && (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt <= '0;
      else if (!run) cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
endmodule

// File: rtl/mdio_txmux.sv
module mdio_txmux
   import mdio_pkg::*;
#(
   parameter int PRE_LEN = 32,
   parameter int CYW     = 6
) (
   input  logic                 busy,
   input  logic                 wr,
   input  logic [CYW-1:0]       cyc,
   input  logic [BODY_BITS-1:0] body,
   output logic                 mdio_o,
   output logic                 mdio_oe
);
   localparam int REL_CYC = PRE_LEN + HDR_BITS;
   int rel;

   always_comb begin
      rel = int'(cyc) - PRE_LEN;
      if (!busy || rel < 0) mdio_o = 1'b1;
      else                  mdio_o = body[$clog2(BODY_BITS)'(BODY_BITS - 1 - rel)];
      mdio_oe = !(busy && !wr && (int'(cyc) >= REL_CYC));
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int DIV         = 25,
   parameter int PRE_LEN     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        rd_err,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int TOTAL   = PRE_LEN + BODY_BITS;
   localparam int CYW     = $clog2(TOTAL);
   localparam int ERR_CYC = PRE_LEN + HDR_BITS + 1;
   localparam int DAT0    = ERR_CYC + 1;
   localparam int LAST    = TOTAL - 1;

   generate
      if (PRE_LEN < 1) begin : g_bad_pre
         $error("mdio_master needs a non-empty preamble");
      end
   endgenerate

   logic                 wr_q;
   logic [BODY_BITS-1:0] body_q;
   logic [CYW-1:0]       cyc;
   logic                 hi_phase;
   logic                 err_q;
   logic [DATA_W-1:0]    shreg;
   logic                 tick;
   logic                 smp;
   logic                 accept;

   assign accept = req_valid && !busy;

   mdio_divider #(.DIV(DIV)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick));

   mdio_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(mdio_i), .dout(smp));

   mdio_txmux #(.PRE_LEN(PRE_LEN), .CYW(CYW)) u_tx (
      .busy(busy), .wr(wr_q), .cyc(cyc), .body(body_q),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         wr_q     <= 1'b0;
         body_q   <= '0;
         cyc      <= '0;
         hi_phase <= 1'b0;
         mdc      <= 1'b0;
         err_q    <= 1'b0;
         shreg    <= '0;
         rd_data  <= '0;
         rd_err   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy     <= 1'b1;
            wr_q     <= req_write;
            body_q   <= build_body(req_write, req_phy, req_reg, req_wdata);
            cyc      <= '0;
            hi_phase <= 1'b0;
            mdc      <= 1'b0;
            err_q    <= 1'b0;
            shreg    <= '0;
         end else if (busy && tick) begin
            if (!hi_phase) begin
               // sample point: end of the low half, before the rising edge
               if (!wr_q && cyc == CYW'(ERR_CYC)) err_q <= smp;
               if (!wr_q && cyc >= CYW'(DAT0))
                  shreg <= {shreg[DATA_W-2:0], smp};
               mdc      <= 1'b1;
               hi_phase <= 1'b1;
            end else begin
               mdc      <= 1'b0;
               hi_phase <= 1'b0;
               if (cyc == CYW'(LAST)) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  rd_err  <= !wr_q && err_q;
                  rd_data <= (wr_q || err_q) ? '0 : shreg;
               end else begin
                  cyc <= cyc + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DIV = 25
) (
   input logic        clk,
   input logic        rst_n,
   input logic        busy,
   input logic        done,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        rd_err,
   input logic [15:0] rd_data
);
   localparam int RW = $clog2(DIV + 1);
   logic          mdc_q;
   logic [RW-1:0] run;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mdc_q <= 1'b0;
         run   <= '0;
      end else begin
         mdc_q <= mdc;
         if (mdc != mdc_q)          run <= '0;
         else if (run != RW'(DIV)) run <= run + 1'b1;
      end

   // R3
   mdc_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc != mdc_q) |-> (run >= RW'(DIV - 1)));
   // R3
   idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && mdio_oe));
   // R2
   tx_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> !mdc);
   // R4 R7
   dir_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_oe) |-> !mdc);
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R5
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_err) |-> (rd_data == 16'h0000));
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mdc(mdc),
   .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_err(rd_err), .rd_data(rd_data));

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
   localparam int DIV = 3;
   localparam int NCYC = 64;
   localparam time HP = DIV * 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [4:0] req_phy = '0, req_reg = '0;
   logic [15:0] req_wdata = '0;
   logic busy, done, rd_err, mdc, mdio_o, mdio_oe;
   logic [15:0] rd_data;
   logic mdio_i = 1'b1;

   int total = 0, bad = 0;
   int rise_cnt = 0;
   logic rec_o [NCYC];
   logic rec_oe[NCYC];
   logic ph_read = 1'b0, ph_present = 1'b1;
   logic [15:0] ph_data = '0;
   logic in_txn = 1'b0, pv = 1'b0, hp_bad = 1'b0;
   time prev = 0;

   always #4 clk = ~clk;

   mdio_master #(.DIV(DIV)) u_mdio_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .rd_err(rd_err),
      .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // PHY model and frame recorder
   initial forever begin
      @(posedge mdc);
      if (rise_cnt < NCYC) begin
         rec_o[rise_cnt]  = mdio_o;
         rec_oe[rise_cnt] = mdio_oe;
      end
      #1;
      begin
         int nxt;
         nxt = rise_cnt + 1;
         if (ph_read && nxt == 47)                  mdio_i = !ph_present;
         else if (ph_read && nxt >= 48 && nxt <= 63) mdio_i = ph_present ? ph_data[63-nxt] : 1'b1;
         else                                        mdio_i = 1'b1;
      end
      rise_cnt++;
   end

   // half-period monitor
   initial forever begin
      @(mdc);
      if (in_txn && pv && ($time - prev) != HP) hp_bad = 1'b1;
      prev = $time;
      pv = in_txn;
   end

   initial begin
      #1_500_000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
   endfunction

   task automatic txn(input logic wr, input logic [4:0] p, input logic [4:0] r,
                      input logic [15:0] d, input logic present, input logic [15:0] pd,
                      input logic poke);
      logic [63:0] ef;
      logic ok_pre, ok_hdr, ok_tail, ok_oe;
      int waitc;
      ef = exp_frame(wr, p, r, d);
      @(negedge clk);
      rise_cnt = 0; ph_read = !wr; ph_present = present; ph_data = pd;
      mdio_i = 1'b1; hp_bad = 1'b0; pv = 1'b0; in_txn = 1'b1;
      req_valid = 1'b1; req_write = wr; req_phy = p; req_reg = r; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = !wr; req_phy = ~p; req_reg = ~r; req_wdata = ~d;
      chk(busy === 1'b1, "R9 busy after accept", busy, 1);
      waitc = 0;
      while (done !== 1'b1 && waitc < 2000) begin
         if (poke && rise_cnt == 10) req_valid = 1'b1;
         else req_valid = 1'b0;
         @(negedge clk);
         waitc++;
      end
      req_valid = 1'b0;
      in_txn = 1'b0;
      chk(done === 1'b1, "R9 done seen", done, 1);
      chk(busy === 1'b0, "R9 busy low at done", busy, 0);
      chk(rise_cnt == NCYC, "R5 mdc rising edge count", rise_cnt, NCYC);
      chk(!hp_bad, "R3 half period", hp_bad, 0);
      ok_pre = 1'b1; ok_hdr = 1'b1; ok_tail = 1'b1; ok_oe = 1'b1;
      for (int i = 0; i < NCYC; i++) begin
         if (i < 32 && (rec_o[i] !== 1'b1 || rec_oe[i] !== 1'b1)) ok_pre = 1'b0;
         if (i >= 32 && i < 46 && (rec_o[i] !== ef[63-i] || rec_oe[i] !== 1'b1)) ok_hdr = 1'b0;
         if (i >= 46 && wr && (rec_o[i] !== ef[63-i] || rec_oe[i] !== 1'b1)) ok_tail = 1'b0;
         if (i >= 46 && !wr && rec_oe[i] !== 1'b0) ok_oe = 1'b0;
      end
      chk(ok_pre, "R1 preamble", ok_pre, 1);
      chk(ok_hdr, "R2 header fields", ok_hdr, 1);
      if (wr) begin
         chk(ok_tail, "R8 write turnaround and data", ok_tail, 1);
         chk(rd_err === 1'b0 && rd_data === 16'h0, "R10 write result", {rd_err, rd_data}, 0);
      end else begin
         chk(ok_oe, "R4 line released for read", ok_oe, 1);
         chk(rd_err === !present, "R5 error flag", rd_err, !present);
         chk(rd_data === (present ? pd : 16'h0), "R6 read data", rd_data, present ? pd : 16'h0);
      end
      chk(mdio_oe === 1'b1 && mdc === 1'b0, "R7 line reclaimed idle", {mdio_oe, mdc}, 2);
      repeat (5) @(negedge clk);
      chk(busy === 1'b0 && rise_cnt == NCYC, "R9 ignored request not started", rise_cnt, NCYC);
   endtask

   initial begin
      void'($urandom(32'd20417));
      repeat (3) @(negedge clk);
      chk(busy === 0 && done === 0 && mdc === 0 && mdio_oe === 1 && mdio_o === 1,
          "R3 reset state", {busy, done, mdc, mdio_oe, mdio_o}, 5'b00011);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      txn(1'b1, 5'd31, 5'd0, 16'hA5C3, 1'b1, 16'h0, 1'b0);
      txn(1'b1, 5'd0, 5'd31, 16'h0001, 1'b1, 16'h0, 1'b0);
      txn(1'b0, 5'd1, 5'd2, 16'h0, 1'b1, 16'hFFFF, 1'b0);
      txn(1'b0, 5'd3, 5'd4, 16'h0, 1'b1, 16'h0000, 1'b0);
      txn(1'b0, 5'd7, 5'd9, 16'h0, 1'b0, 16'hFFFF, 1'b0);
      txn(1'b0, 5'd5, 5'd17, 16'h0, 1'b1, 16'h8001, 1'b1);
      txn(1'b1, 5'd12, 5'd21, 16'h3C5A, 1'b1, 16'h0, 1'b1);
      for (int k = 0; k < 16; k++) begin
         logic [31:0] r;
         r = $urandom;
         txn(r[0], r[5:1], r[10:6], r[26:11], (r[29:27] != 3'd0),
             16'($urandom), 1'b0);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule